// File: doc/BRIEF.md
# SPI Target Frame Receiver

This block is the serial front end of a four-channel register device that sits on an SPI-style bus. It oversamples the bus pins (serial clock, serial input, active-low chip select and active-low hold) in the system clock domain. It assembles the incoming bits into bytes, MSB first, and it screens the first byte of every frame. That byte has to carry a fixed device-type nibble, two zero bits and two address bits that equal the board-strapped address inputs. Accepted bytes go to a command layer as single-cycle strobes, each tagged with its position in the frame. The command layer also sees frame start, completed-frame and aborted-frame events.

For reads, the command layer loads a byte and the block shifts it out MSB first. The output bit changes on falling serial-clock edges, and the output enable marks when the pin would be driven. The host can pause a transfer with the hold input without losing its place in the bit sequence. After reset the block refuses all traffic until it has seen chip select fall, so a bus that is already selected at power-up cannot inject a frame. The system clock must run at least eight times faster than the serial clock.

Top module: `spi_frame_rx`

## Requirements
- R1: After reset, `so_oe`, `byte_valid`, `frame_start`, `frame_end` and `frame_abort` are all low.
- R2: After reset, no byte, completed-frame or aborted-frame event is produced until chip select has gone from high to low. Traffic clocked while chip select stays low from reset onward is ignored.
- R3: `si` is sampled on rising `sck` edges, MSB first. After every eighth sampled bit of an accepted frame, `byte_valid` pulses for one cycle while `rx_byte` holds the byte.
- R4: `byte_idx` is 0 for the first byte of a frame, 1 for the second and 2 for the third and every later byte.
- R5: The first byte is accepted only if bits 7..4 are 0101 and bits 3..2 are 00. Otherwise that byte and every later byte of the frame are dropped and give no `byte_valid`.
- R6: The first byte is accepted only if its bits 1..0 equal `addr_strap[1:0]`. Otherwise the frame is dropped as in R5.
- R7: A `tx_load` pulse puts `tx_byte[7]` on `so`. Each later falling `sck` edge of the frame moves `so` to the next lower bit, except the first falling edge after the load, which leaves bit 7 in place. The host therefore reads the byte MSB first on the next eight rising edges.
- R8: `so_oe` is low whenever chip select is high, whenever `hold_n` is low, and for the rest of a frame whose first byte was rejected. Otherwise it is high.
- R9: When `hold_n` is low while `sck` is low, the transfer pauses. `sck` edges during the pause are ignored and the bit position is kept. When `hold_n` is high while `sck` is low, the transfer resumes. A change of `hold_n` while `sck` is high takes effect only once `sck` is low.
- R10: `frame_start` pulses when chip select falls. When chip select rises, `frame_end` pulses if the first byte was accepted and no byte is partly received. Otherwise `frame_abort` pulses. At most one of the three pulses in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Bus serial clock |
| si | input | 1 | Bus serial data in |
| cs_n | input | 1 | Bus chip select, active low |
| hold_n | input | 1 | Bus pause request, active low |
| addr_strap | input | 2 | Board-strapped device address |
| tx_byte | input | 8 | Byte to send to the host |
| tx_load | input | 1 | Load strobe for `tx_byte` |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for `so` (low means high impedance) |
| rx_byte | output | 8 | Last received byte |
| byte_valid | output | 1 | One-cycle strobe for `rx_byte` |
| byte_idx | output | 2 | Position of `rx_byte` in the frame (0, 1, 2) |
| frame_start | output | 1 | Chip select fell |
| frame_end | output | 1 | Frame closed cleanly |
| frame_abort | output | 1 | Frame closed mid-byte or after a rejected first byte |

## Verification
The bench drives four kinds of bad first byte: a wrong type nibble, a wrong address, nonzero pad bits, and a frame clocked while chip select has been low since reset. A design with a loose comparison or no arming would leak those bytes to the command layer. It pauses with hold in the middle of a byte and toggles `sck` with ones on `si`. A design that kept counting, or that dropped its position, would deliver a misaligned byte. It closes a frame three bits into a byte and expects an abort rather than an end. It reads a loaded byte back bit by bit, which shows whether the design loses or repeats the MSB on the first falling edge after the load.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  // device-type nibble carried in the top of the first frame byte
  localparam logic [3:0] DEV_TYPE = 4'b0101;
  // byte position codes handed to the command layer
  localparam logic [1:0] IDX_ID   = 2'd0;
  localparam logic [1:0] IDX_CMD  = 2'd1;
  localparam logic [1:0] IDX_DATA = 2'd2;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
        else        chain_q <= {chain_q[STAGES-2:0], d[b]};
      end
      assign q[b] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sfr_rx_core.sv
module sfr_rx_core import sfr_pkg::*; #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2,
  localparam int CNT_W = $clog2(BYTE_W),
  localparam int PAD_W = BYTE_W - 4 - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_evt,
  input  logic              close_evt,
  input  logic              bit_stb,
  input  logic              si_s,
  input  logic [ADDR_W-1:0] addr_strap,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_valid,
  output logic [1:0]        byte_idx,
  output logic              frame_start,
  output logic              frame_end,
  output logic              frame_abort,
  output logic              rejected,
  output logic [CNT_W-1:0]  bit_pos
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-2:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [1:0]        idx_q, idx_n, bidx_q, bidx_n;
  logic              idok_q, idok_n, rej_q, rej_n;
  logic [BYTE_W-1:0] rxb_q, rxb_n, full;
  logic              vld_q, vld_n, st_q, st_n, end_q, end_n, ab_q, ab_n;
  logic              id_match, clean;

  always_comb begin
    full     = {sh_q, si_s};
    id_match = (full[BYTE_W-1 -: 4] == DEV_TYPE) &&
               (full[ADDR_W +: PAD_W] == '0) &&
               (full[ADDR_W-1:0] == addr_strap);
    clean    = idok_q && (cnt_q == '0);
    sh_n = sh_q;  cnt_n = cnt_q;  idx_n = idx_q;  idok_n = idok_q;
    rej_n = rej_q; rxb_n = rxb_q; bidx_n = bidx_q;
    vld_n = 1'b0; st_n = 1'b0; end_n = 1'b0; ab_n = 1'b0;
    if (open_evt) begin
      st_n = 1'b1; cnt_n = '0; idx_n = IDX_ID; idok_n = 1'b0; rej_n = 1'b0;
    end else if (close_evt) begin
      end_n = clean; ab_n = ~clean;
      cnt_n = '0; idx_n = IDX_ID; idok_n = 1'b0; rej_n = 1'b0;
    end else if (bit_stb && !rej_q) begin
      sh_n = full[BYTE_W-2:0];
      if (cnt_q == LAST) begin
        cnt_n = '0;
        if (idx_q == IDX_ID && !id_match) begin
          rej_n = 1'b1;
        end else begin
          vld_n  = 1'b1;
          rxb_n  = full;
          bidx_n = idx_q;
          case (idx_q)
            IDX_ID:  begin idx_n = IDX_CMD; idok_n = 1'b1; end
            IDX_CMD: idx_n = IDX_DATA;
            default: idx_n = IDX_DATA;
          endcase
        end
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; cnt_q <= '0; idx_q <= IDX_ID; bidx_q <= IDX_ID;
      idok_q <= 1'b0; rej_q <= 1'b0; rxb_q <= '0;
      vld_q <= 1'b0; st_q <= 1'b0; end_q <= 1'b0; ab_q <= 1'b0;
    end else begin
      sh_q <= sh_n; cnt_q <= cnt_n; idx_q <= idx_n; bidx_q <= bidx_n;
      idok_q <= idok_n; rej_q <= rej_n; rxb_q <= rxb_n;
      vld_q <= vld_n; st_q <= st_n; end_q <= end_n; ab_q <= ab_n;
    end
  end

  assign rx_byte     = rxb_q;
  assign byte_valid  = vld_q;
  assign byte_idx    = bidx_q;
  assign frame_start = st_q;
  assign frame_end   = end_q;
  assign frame_abort = ab_q;
  assign rejected    = rej_q;
  assign bit_pos     = cnt_q;
endmodule

// File: rtl/sfr_tx_shift.sv
module sfr_tx_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] data,
  input  logic              shift_stb,
  output logic              so
);
  logic [BYTE_W-1:0] sr_q, sr_n;
  logic              first_q, first_n;

  always_comb begin
    sr_n = sr_q;
    first_n = first_q;
    if (load) begin
      sr_n = data;
      first_n = 1'b1;
    end else if (shift_stb) begin
      if (first_q) first_n = 1'b0;
      else         sr_n = {sr_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      first_q <= 1'b0;
    end else begin
      sr_q <= sr_n;
      first_q <= first_n;
    end
  end

  assign so = sr_q[BYTE_W-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx import sfr_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              si,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic [ADDR_W-1:0] addr_strap,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_load,
  output logic              so,
  output logic              so_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_valid,
  output logic [1:0]        byte_idx,
  output logic              frame_start,
  output logic              frame_end,
  output logic              frame_abort
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic sck_s, si_s, hold_s, cs_s;
  logic sck_d, cs_d;
  logic in_frame_q, in_frame_n, paused_q, paused_n;
  logic sck_rise, sck_fall, cs_fall, cs_rise;
  logic bit_stb, shift_stb, close_evt, rejected;
  logic [CNT_W-1:0] bit_pos;

  // chip select resets to "low" so a bus held selected through reset
  // never shows a falling edge and cannot open a frame
  sfr_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck, si, hold_n, cs_n}),
    .q({sck_s, si_s, hold_s, cs_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  assign sck_rise  = sck_s & ~sck_d;
  assign sck_fall  = ~sck_s & sck_d;
  assign cs_fall   = ~cs_s & cs_d;
  assign cs_rise   = cs_s & ~cs_d;
  assign close_evt = cs_rise & in_frame_q;

  always_comb begin
    in_frame_n = in_frame_q;
    if (cs_fall)      in_frame_n = 1'b1;
    else if (cs_rise) in_frame_n = 1'b0;
    paused_n = paused_q;
    if (!in_frame_q || cs_rise) paused_n = 1'b0;
    else if (!sck_s)            paused_n = ~hold_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      paused_q   <= 1'b0;
    end else begin
      in_frame_q <= in_frame_n;
      paused_q   <= paused_n;
    end
  end

  assign bit_stb   = in_frame_q & ~paused_q & sck_rise;
  assign shift_stb = in_frame_q & ~paused_q & sck_fall;
  assign so_oe     = in_frame_q & hold_s & ~paused_q & ~rejected;

  sfr_rx_core #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .open_evt(cs_fall), .close_evt(close_evt), .bit_stb(bit_stb),
    .si_s(si_s), .addr_strap(addr_strap),
    .rx_byte(rx_byte), .byte_valid(byte_valid), .byte_idx(byte_idx),
    .frame_start(frame_start), .frame_end(frame_end),
    .frame_abort(frame_abort), .rejected(rejected), .bit_pos(bit_pos)
  );

  sfr_tx_shift #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load(tx_load), .data(tx_byte), .shift_stb(shift_stb), .so(so)
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker import sfr_pkg::*; #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_frame,
  input logic              paused,
  input logic              hold_s,
  input logic [CNT_W-1:0]  bit_pos,
  input logic              so_oe,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              byte_valid,
  input logic [1:0]        byte_idx,
  input logic [ADDR_W-1:0] addr_strap,
  input logic              frame_start,
  input logic              frame_end,
  input logic              frame_abort
);
  AST_VALID_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rst_n) byte_valid |-> $past(in_frame)); // R3
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) byte_valid |-> (byte_idx <= IDX_DATA)); // R4
  AST_ID_TYPE_OK: assert property (@(posedge clk) disable iff (!rst_n) (byte_valid && byte_idx == IDX_ID) |-> (rx_byte[BYTE_W-1 -: 4] == DEV_TYPE)); // R5
  AST_ID_ADDR_OK: assert property (@(posedge clk) disable iff (!rst_n) (byte_valid && byte_idx == IDX_ID) |-> (rx_byte[ADDR_W-1:0] == addr_strap)); // R6
  AST_OE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) !in_frame |-> !so_oe); // R8
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !hold_s |-> !so_oe); // R8
  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) paused |=> (!in_frame || $stable(bit_pos))); // R9
  AST_EVENT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({frame_start, frame_end, frame_abort})); // R10
endmodule

bind spi_frame_rx sfr_checker #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_frame(in_frame_q), .paused(paused_q),
  .hold_s(hold_s), .bit_pos(bit_pos), .so_oe(so_oe), .rx_byte(rx_byte),
  .byte_valid(byte_valid), .byte_idx(byte_idx), .addr_strap(addr_strap),
  .frame_start(frame_start), .frame_end(frame_end), .frame_abort(frame_abort)
);

// File: tb/spi_frame_rx_test.sv
module spi_frame_rx_test;
  localparam int H = 10;
  localparam logic [1:0] K_BYTE = 2'd0, K_END = 2'd1, K_ABORT = 2'd2;
  localparam logic [7:0] TXV = 8'hC6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, si = 1'b0, cs_n = 1'b0, hold_n = 1'b1;
  logic [1:0] addr_strap = 2'b10;
  logic [7:0] tx_byte = 8'h00;
  logic tx_load = 1'b0;
  logic so, so_oe, byte_valid, frame_start, frame_end, frame_abort;
  logic [7:0] rx_byte;
  logic [1:0] byte_idx;

  int checks = 0, fails = 0, n_start = 0, n_evt = 0;
  bit done = 1'b0;
  logic [11:0] exp_q[$];
  string req_q[$];

  always #2 clk = ~clk;

  spi_frame_rx uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
    .addr_strap(addr_strap), .tx_byte(tx_byte), .tx_load(tx_load),
    .so(so), .so_oe(so_oe), .rx_byte(rx_byte), .byte_valid(byte_valid),
    .byte_idx(byte_idx), .frame_start(frame_start), .frame_end(frame_end),
    .frame_abort(frame_abort)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input string req, input logic [1:0] kind,
                      input logic [1:0] idx, input logic [7:0] val);
    exp_q.push_back({kind, idx, val});
    req_q.push_back(req);
  endtask

  task automatic pop_cmp(input logic [11:0] got);
    if (exp_q.size() == 0) begin
      check("unexpected(R2,R5,R6)", "event with nothing expected", {20'd0, got}, 32'hFFF);
    end else begin
      logic [11:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(r, "event {kind,idx,byte}", {20'd0, got}, {20'd0, e});
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid)  begin n_evt++; pop_cmp({K_BYTE, byte_idx, rx_byte}); end
      if (frame_end)   begin n_evt++; pop_cmp({K_END, 2'd0, 8'd0}); end
      if (frame_abort) begin n_evt++; pop_cmp({K_ABORT, 2'd0, 8'd0}); end
      if (frame_start) n_start++;
    end
  end

  // command layer model: answers a 0x9C instruction with a read byte
  always @(negedge clk) begin
    tx_load <= 1'b0;
    if (rst_n && byte_valid && byte_idx == 2'd1 && rx_byte == 8'h9C) begin
      tx_load <= 1'b1;
      tx_byte <= TXV;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    si = b; tick(H); sck = 1'b1; tick(H); sck = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] v, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) send_bit(v[i]);
  endtask

  task automatic cs_low;
    cs_n = 1'b0; tick(H);
  endtask

  task automatic cs_high;
    tick(H); cs_n = 1'b1; tick(2 * H);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  initial begin
    logic [7:0] got;
    int starts0;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    // R1: idle outputs after reset
    check("R1", "so_oe", so_oe, 0);
    check("R1", "byte_valid", byte_valid, 0);
    check("R1", "frame events", {frame_start, frame_end, frame_abort}, 0);

    // R2: bus selected since reset, full frame clocked in, then released
    send_bits(8'h52, 7, 0);
    send_bits(8'hA5, 7, 0);
    cs_high();
    check("R2", "events before first select fall", n_evt, 0);
    check("R2", "so_oe before first select fall", so_oe, 0);

    // R3 R4 R10: good frame, two data bytes (idx saturates at 2)
    starts0 = n_start;
    cs_low();
    check("R10", "frame_start count", n_start - starts0, 1);
    check("R8", "so_oe while selected", so_oe, 1);
    push("R3", K_BYTE, 2'd0, 8'h52); send_bits(8'h52, 7, 0);
    push("R4", K_BYTE, 2'd1, 8'hA5); send_bits(8'hA5, 7, 0);
    push("R4", K_BYTE, 2'd2, 8'h3C); send_bits(8'h3C, 7, 0);
    push("R4", K_BYTE, 2'd2, 8'h81); send_bits(8'h81, 7, 0);
    push("R10", K_END, 2'd0, 8'h00);
    cs_high();
    check("R8", "so_oe after deselect", so_oe, 0);

    // R5: wrong type nibble
    cs_low(); push("R5", K_ABORT, 2'd0, 8'h00);
    send_bits(8'h62, 7, 0); send_bits(8'hA5, 7, 0);
    check("R8", "so_oe after rejected id", so_oe, 0);
    cs_high();

    // R5: nonzero pad bits
    cs_low(); push("R5", K_ABORT, 2'd0, 8'h00);
    send_bits(8'h56, 7, 0); send_bits(8'h11, 7, 0);
    cs_high();

    // R6: wrong address bits
    cs_low(); push("R6", K_ABORT, 2'd0, 8'h00);
    send_bits(8'h51, 7, 0); send_bits(8'hA5, 7, 0);
    cs_high();

    // R6: other strap value accepted
    addr_strap = 2'b01;
    cs_low();
    push("R6", K_BYTE, 2'd0, 8'h51); send_bits(8'h51, 7, 0);
    push("R10", K_END, 2'd0, 8'h00);
    cs_high();
    addr_strap = 2'b10;

    // R10: close three bits into a byte
    cs_low();
    push("R3", K_BYTE, 2'd0, 8'h52); send_bits(8'h52, 7, 0);
    push("R10", K_ABORT, 2'd0, 8'h00); send_bits(8'hE0, 7, 5);
    cs_high();

    // R9: hold in the middle of the instruction byte
    cs_low();
    push("R9", K_BYTE, 2'd0, 8'h52); send_bits(8'h52, 7, 0);
    push("R9", K_BYTE, 2'd1, 8'hA5); send_bits(8'hA5, 7, 4);
    check("R8", "so_oe before hold", so_oe, 1);
    hold_n = 1'b0; tick(H);
    check("R8", "so_oe during hold", so_oe, 0);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    check("R9", "no event while paused", exp_q.size(), 1);
    hold_n = 1'b1; tick(H);
    check("R9", "so_oe after resume", so_oe, 1);
    send_bits(8'hA5, 3, 0);
    push("R10", K_END, 2'd0, 8'h00);
    cs_high();

    // R7: read byte shifted out on SO
    cs_low();
    push("R3", K_BYTE, 2'd0, 8'h52); send_bits(8'h52, 7, 0);
    push("R7", K_BYTE, 2'd1, 8'h9C); send_bits(8'h9C, 7, 0);
    push("R7", K_BYTE, 2'd2, 8'h00);
    got = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      si = 1'b0; tick(H);
      got = {got[6:0], so};
      sck = 1'b1; tick(H); sck = 1'b0;
    end
    check("R7", "byte read on so", got, TXV);
    push("R10", K_END, 2'd0, 8'h00);
    cs_high();

    tick(2 * H);
    check("R10", "all expected events seen", exp_q.size(), 0);
    summary();
  end
endmodule